// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers the interrupt sources outside a small 8-bit CPU core into one request line. One source is a dedicated active-low interrupt pin. The others are eight general-purpose port pins, and each of these counts as a source only while its pullup is enabled. All sources are merged into one active-low level. That level passes through a flip-flop synchronizer. A falling edge on the synchronized level sets a request latch. A configuration input chooses the trigger mode: edge only, or edge plus low level, in which case a source held low keeps requesting.

The CPU provides a global mask bit, an instruction-fetch strobe qualified by a trap indication, and a 2-bit acknowledge code. The block combines these with the latch and with a pending software trap. From them it drives a request line and the 16-bit address where the selected vector is stored. When the CPU accepts a source, the acknowledge clears only that source's latch. So a pulse that arrives while the handler runs is kept, and it is taken as soon as the mask is cleared. A software trap is never masked. If a hardware request was already pending and unmasked when the trap was fetched, that request is served before the trap. A hardware request that arrives later is served after the trap. The block also returns the synchronized merged level, which the CPU uses for branch-on-pin tests.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the external latch and the trap are clear, `req_o` is 0, `pin_level_o` is 1 and `vec_o` is 0x3FFA.
- R2: The merged source is `irq_pin_n` ANDed with every port pin whose `pullup_en` bit is 1. Its level reaches `pin_level_o` on the second rising clock edge after it changes.
- R3: While `mask_i` is 1, an external request does not raise `req_o`, but the latch keeps it. Once `mask_i` is 0, `req_o` rises.
- R4: With `level_mode`=0, only a falling edge of the merged level sets the latch. After an external acknowledge, a source that stays low produces no further request.
- R5: With `level_mode`=1, a low synchronized merged level requests by itself, even after an external acknowledge.
- R6: A port pin whose `pullup_en` bit is 0 creates no request, whatever it does.
- R7: `ack_i`=2'b01 clears only the external latch. `ack_i`=2'b10 clears only the pending trap. 2'b00 and 2'b11 clear nothing.
- R8: A falling edge that arrives after an external acknowledge sets the latch again. This holds even in the same cycle as the acknowledge, because setting wins over clearing.
- R9: `vec_o` is 0x3FFC whenever the trap is the selected source. Otherwise it is 0x3FFA.
- R10: A trap, recorded when `fetch_i` and `swi_i` are both 1 on a clock edge, raises `req_o` whatever the value of `mask_i`.
- R11: If an external request is pending and unmasked when the trap is fetched, it is selected before the trap. An external request that arrives after that fetch is selected after the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_n | input | 1 | Dedicated active-low interrupt pin |
| port_pin | input | 8 | General-purpose port pins |
| pullup_en | input | 8 | Per-pin pullup enable; 1 makes the pin a source |
| level_mode | input | 1 | 0 = falling edge only, 1 = falling edge plus low level |
| mask_i | input | 1 | Global mask of external requests |
| fetch_i | input | 1 | Instruction-fetch strobe |
| swi_i | input | 1 | Fetched instruction is a software trap |
| ack_i | input | 2 | Acknowledge: 01 external, 10 trap |
| req_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Address of the high byte of the selected vector |
| pin_level_o | output | 1 | Synchronized merged source level |

## Verification
The bench drives random patterns of port pulses against random pullup enables. A controller that ignored the enables would raise requests from pins that are not sources. One that dropped enabled pins would miss real requests. Directed cases cover these faults:
- A pulse during the handler: a design that cleared the whole latch late, or on unmask, would lose it.
- A pin held low across an acknowledge, in both modes: this exposes a level/edge mix-up.
- Trap fetches placed before and after a hardware pulse: a fixed-priority arbiter would deliver one of the two orders wrongly.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    typedef enum logic [1:0] {
        ACK_NONE = 2'b00,
        ACK_EXT  = 2'b01,
        ACK_SWI  = 2'b10,
        ACK_RSVD = 2'b11
    } ack_e;

    typedef struct packed {
        logic prev_lvl;
        logic ext_latch;
        logic swi_pend;
        logic ext_first;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{prev_lvl: 1'b1, ext_latch: 1'b0,
                                   swi_pend: 1'b0, ext_first: 1'b0};
endpackage

// File: rtl/eirq_src_merge.sv
module eirq_src_merge #(
    parameter int PORT_W = 8
) (
    input  logic              irq_pin_n,
    input  logic [PORT_W-1:0] port_pin,
    input  logic [PORT_W-1:0] pullup_en,
    output logic              merged_n
);
    logic [PORT_W-1:0] gated;

    for (genvar i = 0; i < PORT_W; i++) begin : g_gate
        assign gated[i] = port_pin[i] | ~pullup_en[i];
    end

    assign merged_n = irq_pin_n & (&gated);
endmodule

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter (
    input  logic ext_pend,
    input  logic mask,
    input  logic swi_pend,
    input  logic ext_first,
    output logic req,
    output logic sel_swi
);
    logic ext_live;

    always_comb begin
        ext_live = ext_pend & ~mask;
        req      = swi_pend | ext_live;
        sel_swi  = swi_pend & ~(ext_first & ext_live);
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
    parameter int          PORT_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] EXT_VEC     = 16'h3FFA,
    parameter logic [15:0] SWI_VEC     = 16'h3FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic [PORT_W-1:0] port_pin,
    input  logic [PORT_W-1:0] pullup_en,
    input  logic              level_mode,
    input  logic              mask_i,
    input  logic              fetch_i,
    input  logic              swi_i,
    input  logic [1:0]        ack_i,
    output logic              req_o,
    output logic [15:0]       vec_o,
    output logic              pin_level_o
);
    import eirq_pkg::*;

    logic   merged_n;
    logic   lvl_sync;
    logic   fall_det;
    logic   ext_pend;
    logic   sel_swi;
    ack_e   ack;
    ctl_t   st_d, st_q;

    eirq_src_merge #(.PORT_W(PORT_W)) u_merge (
        .irq_pin_n (irq_pin_n),
        .port_pin  (port_pin),
        .pullup_en (pullup_en),
        .merged_n  (merged_n)
    );

    eirq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (merged_n),
        .dout  (lvl_sync)
    );

    always_comb begin
        ack      = ack_e'(ack_i);
        fall_det = st_q.prev_lvl & ~lvl_sync;
        ext_pend = st_q.ext_latch | (level_mode & ~lvl_sync);

        st_d          = st_q;
        st_d.prev_lvl = lvl_sync;
        if (ack == ACK_EXT) begin
            st_d.ext_latch = 1'b0;
            st_d.ext_first = 1'b0;
        end
        if (ack == ACK_SWI) begin
            st_d.swi_pend  = 1'b0;
            st_d.ext_first = 1'b0;
        end
        if (fall_det) begin
            st_d.ext_latch = 1'b1;
        end
        if (fetch_i && swi_i) begin
            st_d.swi_pend  = 1'b1;
            st_d.ext_first = ext_pend & ~mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CTL_RESET;
        else        st_q <= st_d;
    end

    eirq_arbiter u_arb (
        .ext_pend  (ext_pend),
        .mask      (mask_i),
        .swi_pend  (st_q.swi_pend),
        .ext_first (st_q.ext_first),
        .req       (req_o),
        .sel_swi   (sel_swi)
    );

    assign vec_o       = sel_swi ? SWI_VEC : EXT_VEC;
    assign pin_level_o = lvl_sync;
endmodule

// File: rtl/eirq_checks.sv
module eirq_checks #(
    parameter logic [15:0] EXT_VEC = 16'h3FFA,
    parameter logic [15:0] SWI_VEC = 16'h3FFC
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mask_i,
    input logic        level_mode,
    input logic [1:0]  ack_i,
    input logic        req_o,
    input logic [15:0] vec_o,
    input logic        lvl_sync,
    input logic        fall_det,
    input logic        ext_latch,
    input logic        swi_pend
);
    a_r3_mask_blocks_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !swi_pend) |-> !req_o);

    a_r10_trap_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        swi_pend |-> req_o);

    a_r9_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (vec_o == EXT_VEC || vec_o == SWI_VEC));

    a_r8_edge_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        fall_det |=> ext_latch);

    a_r7_ack_clears_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i == 2'b01 && !fall_det) |=> !ext_latch);

    a_r5_level_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !lvl_sync && !mask_i) |-> req_o);
endmodule

bind ext_irq_ctrl eirq_checks #(.EXT_VEC(EXT_VEC), .SWI_VEC(SWI_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_i     (mask_i),
    .level_mode (level_mode),
    .ack_i      (ack_i),
    .req_o      (req_o),
    .vec_o      (vec_o),
    .lvl_sync   (lvl_sync),
    .fall_det   (fall_det),
    .ext_latch  (st_q.ext_latch),
    .swi_pend   (st_q.swi_pend)
);

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [15:0] EV = 16'h3FFA;
    localparam logic [15:0] SV = 16'h3FFC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic [7:0] port_pin = 8'hFF;
    logic [7:0] pullup_en = 8'h00;
    logic       level_mode = 1'b0;
    logic       mask_i = 1'b1;
    logic       fetch_i = 1'b0;
    logic       swi_i = 1'b0;
    logic [1:0] ack_i = 2'b00;
    logic       req_o;
    logic [15:0] vec_o;
    logic       pin_level_o;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin(port_pin),
        .pullup_en(pullup_en), .level_mode(level_mode), .mask_i(mask_i),
        .fetch_i(fetch_i), .swi_i(swi_i), .ack_i(ack_i), .req_o(req_o),
        .vec_o(vec_o), .pin_level_o(pin_level_o)
    );

    function automatic logic exp_source_fell(logic [7:0] pins, logic [7:0] en);
        return |(~pins & en);
    endfunction

    function automatic logic [15:0] exp_vec(logic trap_selected);
        return trap_selected ? SV : EV;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ack(logic [1:0] code);
        ack_i = code;
        step(1);
        ack_i = 2'b00;
    endtask

    task automatic trap_fetch();
        fetch_i = 1'b1;
        swi_i   = 1'b1;
        step(1);
        fetch_i = 1'b0;
        swi_i   = 1'b0;
    endtask

    task automatic pin_pulse();
        irq_pin_n = 1'b0;
        step(2);
        irq_pin_n = 1'b1;
        step(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 req", req_o, 0);
        chk("R1 level", pin_level_o, 1);
        chk("R1 vec", vec_o, EV);

        // R2 sync latency of the merged level
        irq_pin_n = 1'b0;
        step(1);
        chk("R2 one edge", pin_level_o, 1);
        step(1);
        chk("R2 two edges", pin_level_o, 0);
        irq_pin_n = 1'b1;
        step(4);

        // R3 masked pulse held, then serviced after unmask
        chk("R3 masked", req_o, 0);
        mask_i = 1'b0;
        step(1);
        chk("R3 unmasked", req_o, 1);
        chk("R9 ext vec", vec_o, exp_vec(0));
        ack(2'b11);
        chk("R7 code 11 no clear", req_o, 1);
        ack(2'b10);
        chk("R7 code 10 keeps ext", req_o, 1);
        ack(2'b01);
        chk("R7 ext ack clears", req_o, 0);

        // R8 pulse during handler held until unmask
        mask_i = 1'b1;
        pin_pulse();
        chk("R8 held while masked", req_o, 0);
        mask_i = 1'b0;
        step(1);
        chk("R8 served on unmask", req_o, 1);
        ack(2'b01);

        // R4 edge mode: held low, no re-request after ack
        irq_pin_n = 1'b0;
        step(4);
        chk("R4 edge request", req_o, 1);
        ack(2'b01);
        step(3);
        chk("R4 no re-request", req_o, 0);
        irq_pin_n = 1'b1;
        step(4);

        // R5 level mode re-requests while low
        level_mode = 1'b1;
        irq_pin_n = 1'b0;
        step(4);
        ack(2'b01);
        step(2);
        chk("R5 still requesting", req_o, 1);
        irq_pin_n = 1'b1;
        step(3);
        chk("R5 release", req_o, 0);
        level_mode = 1'b0;

        // R10 trap while masked
        mask_i = 1'b1;
        trap_fetch();
        chk("R10 trap req", req_o, 1);
        chk("R9 trap vec", vec_o, exp_vec(1));
        ack(2'b01);
        chk("R7 ext ack keeps trap", req_o, 1);
        ack(2'b10);
        chk("R7 trap ack clears", req_o, 0);
        mask_i = 1'b0;

        // R11 ext pending before fetch goes first
        pin_pulse();
        trap_fetch();
        chk("R11 ext first", vec_o, EV);
        ack(2'b01);
        chk("R11 then trap", vec_o, SV);
        ack(2'b10);
        chk("R11 done A", req_o, 0);

        // R11 ext arriving after fetch goes after
        trap_fetch();
        pin_pulse();
        chk("R11 trap first", vec_o, SV);
        ack(2'b10);
        chk("R11 then ext", vec_o, EV);
        chk("R11 ext still req", req_o, 1);
        ack(2'b01);
        chk("R11 done B", req_o, 0);

        // R6 / R2 random port pulses against random pullup enables
        for (int t = 0; t < 60; t++) begin
            logic [7:0] en;
            logic [7:0] pat;
            logic       fell;
            en  = 8'($urandom);
            pat = 8'($urandom) | 8'($urandom);
            fell = exp_source_fell(pat, en);
            pullup_en = en;
            step(1);
            port_pin = pat;
            step(2);
            chk("R2 merged level", pin_level_o, !fell);
            port_pin = 8'hFF;
            step(4);
            chk("R6 port request", req_o, fell);
            if (req_o) chk("R9 port vec", vec_o, EV);
            if (fell) ack(2'b01);
        end
        pullup_en = 8'h00;
        port_pin = 8'h00;
        step(5);
        chk("R6 disabled pins ignored", req_o, 0);
        chk("R6 disabled level", pin_level_o, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule